// File: doc/BRIEF.md
# Four-to-Five Word Unpacker with Lane FIFOs

This block sits on the receive side of a serial link that carries sample data packed into 20-bit words. It gathers the 20-bit words in groups of four, treats each group as one 80-bit vector, and cuts that vector into five 16-bit sample words. Each of the five words is written into its own lane FIFO, so one lane always receives the same position of every group. A set of ten samples covers two groups, so each lane receives two words per set.

The sender marks the first 20-bit word of every sample set with a flag. The block uses this flag to realign its group counter, and it tags the first sample word of each set in lane 0 with a marker bit. If the flag arrives while a group is only partly collected, the partial group is dropped and a sticky alignment error is raised. Each lane FIFO is show-ahead, with its own read enable, full and empty flags and a sticky overflow flag.

Top module: `lane_unpack`

## Requirements
- R1: Accepted input word j of a group (j = 0..3) occupies bits [20j+19:20j] of an 80-bit group vector, and output word k (k = 0..4) is bits [16k+15:16k] of that vector, so the concatenation of lanes 4..0 equals the group vector.
- R2: Output word k is written to lane k; all five lanes are written on the clock edge that accepts the fourth word of a group, and the word is visible on that lane's slice of rd_data (bits [16k+15:16k]), with empty low, from the next cycle on.
- R3: rd_first[0] is 1 for the lane-0 word of a group that starts a sample set and 0 for the second group of the set; a group starts a set when its first word carries in_first, or when the previous group was the second of a set. rd_first of lanes 1..4 is always 0.
- R4: Each lane FIFO holds 16 words, returns them in write order, shows full when holding 16 and empty when holding none; a read enable on an empty lane has no effect.
- R5: An accepted word with in_first high while a group is partly collected discards the partial words, sets sync_err (sticky until reset), and becomes word 0 of a new group.
- R6: A write into a full lane is dropped (the lane keeps its 16 stored words) and sets that lane's overflow bit, which stays set until reset.
- R7: While in_valid is low, in_data and in_first have no effect on the group being collected or on sync_err.
- R8: After reset all lanes are empty, full, overflow and sync_err are low, and the group counter starts at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 20 | Packed input word |
| in_first | input | 1 | First word of a sample set (qualified by in_valid) |
| rd_en | input | 5 | Per-lane read enable (pops head word) |
| rd_data | output | 80 | Head word of each lane, lane k at bits [16k+15:16k] |
| rd_first | output | 5 | Head-word set marker per lane |
| empty | output | 5 | Per-lane empty flag |
| full | output | 5 | Per-lane full flag |
| overflow | output | 5 | Per-lane sticky overflow flag |
| sync_err | output | 1 | Sticky mid-group alignment error |

## Verification
The bench builds the block with its default parameters: 20-bit input words, 16-bit lanes, groups of four, and 16-deep lane FIFOs, which derive five lanes. With a depth of 16 the overflow boundary is reached after sixteen groups, so filling, dropping the seventeenth group and draining in order all fit in a short run. The group size of four lets the bench place the alignment flag at every slot of a group and walk the set marker across both halves of a set.

// File: rtl/unpk_pkg.sv
package unpk_pkg;

   // Number of output lanes produced by one group of input words.
   function automatic int lane_count(input int in_w, input int in_words, input int out_w);
      return (in_w * in_words) / out_w;
   endfunction

   // Counter width able to index n positions (at least one bit).
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/unpk_assembler.sv
module unpk_assembler
   import unpk_pkg::*;
#(
   parameter int IN_W     = 20,
   parameter int IN_WORDS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [IN_W-1:0]          in_data,
   input  logic                     in_first,
   output logic                     grp_push,
   output logic [IN_W*IN_WORDS-1:0] grp_data,
   output logic                     grp_mark,
   output logic                     sync_err
);

   localparam int CW    = idx_width(IN_WORDS);
   localparam int ACC_W = IN_W * (IN_WORDS - 1);

   logic [CW-1:0]    cnt;
   logic [CW-1:0]    slot;
   logic [ACC_W-1:0] acc;
   logic             half;
   logic             base_half;
   logic             last;

   // A flagged word always lands in slot 0 of a fresh group.
   assign slot      = in_first ? '0 : cnt;
   assign last      = in_valid && (slot == CW'(IN_WORDS - 1));
   assign base_half = in_first ? 1'b0 : half;

   assign grp_push  = last;
   assign grp_data  = {in_data, acc};
   assign grp_mark  = ~base_half;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         acc      <= '0;
         half     <= 1'b0;
         sync_err <= 1'b0;
      end else if (in_valid) begin
         if (in_first && (cnt != '0))
            sync_err <= 1'b1;
         for (int j = 0; j < IN_WORDS - 1; j++) begin
            if (slot == CW'(j))
               acc[j*IN_W +: IN_W] <= in_data;
         end
         cnt  <= last ? '0 : slot + CW'(1);
         half <= last ? ~base_half : base_half;
      end
   end

endmodule

// File: rtl/unpk_lane_fifo.sv
module unpk_lane_fifo
   import unpk_pkg::*;
#(
   parameter int W     = 17,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         full,
   output logic         empty,
   output logic         ovf
);

   localparam int AW   = idx_width(DEPTH);
   localparam int CNTW = $clog2(DEPTH + 1);

   logic [W-1:0]    mem [DEPTH];
   logic [AW-1:0]   wptr, rptr, wnext, rnext;
   logic [CNTW-1:0] cnt;
   logic            do_wr, do_rd;

   assign full    = (cnt == CNTW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_wr   = wr_en && !full;
   assign do_rd   = rd_en && !empty;
   assign rd_data = mem[rptr];

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wnext = wptr + AW'(1);
         assign rnext = rptr + AW'(1);
      end else begin : g_mod
         assign wnext = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
         assign rnext = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_wr)
         mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
         ovf  <= 1'b0;
      end else begin
         if (do_wr) wptr <= wnext;
         if (do_rd) rptr <= rnext;
         case ({do_wr, do_rd})
            2'b10:   cnt <= cnt + CNTW'(1);
            2'b01:   cnt <= cnt - CNTW'(1);
            default: cnt <= cnt;
         endcase
         if (wr_en && full)
            ovf <= 1'b1;
      end
   end

endmodule

// File: rtl/lane_unpack.sv
module lane_unpack
   import unpk_pkg::*;
#(
   parameter int IN_W     = 20,
   parameter int OUT_W    = 16,
   parameter int IN_WORDS = 4,
   parameter int DEPTH    = 16,
   parameter int LANES    = lane_count(IN_W, IN_WORDS, OUT_W)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [IN_W-1:0]        in_data,
   input  logic                   in_first,
   input  logic [LANES-1:0]       rd_en,
   output logic [LANES*OUT_W-1:0] rd_data,
   output logic [LANES-1:0]       rd_first,
   output logic [LANES-1:0]       empty,
   output logic [LANES-1:0]       full,
   output logic [LANES-1:0]       overflow,
   output logic                   sync_err
);

   localparam int GRP_W = IN_W * IN_WORDS;
   localparam int ENT_W = OUT_W + 1;

   generate
      if (GRP_W != LANES * OUT_W) begin : g_bad_ratio
         $error("lane_unpack: group width must split evenly into lanes");
      end
      if (IN_WORDS < 2) begin : g_bad_words
         $error("lane_unpack: a group needs at least two input words");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("lane_unpack: lane FIFO depth must be at least two");
      end
   endgenerate

   logic             grp_push;
   logic [GRP_W-1:0] grp_data;
   logic             grp_mark;

   unpk_assembler #(
      .IN_W     (IN_W),
      .IN_WORDS (IN_WORDS)
   ) u_asm (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_first (in_first),
      .grp_push (grp_push),
      .grp_data (grp_data),
      .grp_mark (grp_mark),
      .sync_err (sync_err)
   );

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         logic [ENT_W-1:0] lane_in;
         logic [ENT_W-1:0] lane_out;

         if (k == 0) begin : g_head
            assign lane_in = {grp_mark, grp_data[k*OUT_W +: OUT_W]};
         end else begin : g_body
            assign lane_in = {1'b0, grp_data[k*OUT_W +: OUT_W]};
         end

         unpk_lane_fifo #(
            .W     (ENT_W),
            .DEPTH (DEPTH)
         ) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (grp_push),
            .wr_data (lane_in),
            .rd_en   (rd_en[k]),
            .rd_data (lane_out),
            .full    (full[k]),
            .empty   (empty[k]),
            .ovf     (overflow[k])
         );

         assign rd_data[k*OUT_W +: OUT_W] = lane_out[OUT_W-1:0];
         assign rd_first[k]               = lane_out[OUT_W];
      end
   endgenerate

endmodule

// File: rtl/lane_unpack_chk.sv
module lane_unpack_chk #(
   parameter int LANES = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [LANES-1:0] rd_en,
   input logic [LANES-1:0] rd_first,
   input logic [LANES-1:0] empty,
   input logic [LANES-1:0] full,
   input logic [LANES-1:0] overflow,
   input logic             sync_err
);

   // R5: alignment error is sticky
   assert_sync_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sync_err |=> sync_err);

   // R7: with no valid word and no reads, lane occupancy and error state hold
   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && (rd_en == '0)) |=> ($stable(empty) && $stable(full) && $stable(sync_err)));

   // R3: a marked head word only exists in a lane holding data
   assert_marker_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_first[0] |-> !empty[0]);

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
         // R4: full and empty exclude each other
         assert_flags_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !(full[i] && empty[i]));

         // R6: overflow is sticky
         assert_no_overflow_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            overflow[i] |=> overflow[i]);

         // R6: overflow only rises after the lane was full
         assert_overflow_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(overflow[i]) |-> $past(full[i]));

         // R2: a lane fills only after an accepted input word
         assert_fill_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(empty[i]) |-> $past(in_valid));
      end
   endgenerate

endmodule

bind lane_unpack lane_unpack_chk #(
   .LANES (LANES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .rd_en    (rd_en),
   .rd_first (rd_first),
   .empty    (empty),
   .full     (full),
   .overflow (overflow),
   .sync_err (sync_err)
);

// File: tb/lane_unpack_test.sv
module lane_unpack_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [19:0] in_data;
   logic        in_first;
   logic [4:0]  rd_en;
   logic [79:0] rd_data;
   logic [4:0]  rd_first;
   logic [4:0]  empty;
   logic [4:0]  full;
   logic [4:0]  overflow;
   logic        sync_err;

   int checks   = 0;
   int failures = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   lane_unpack uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_first (in_first),
      .rd_en    (rd_en),
      .rd_data  (rd_data),
      .rd_first (rd_first),
      .empty    (empty),
      .full     (full),
      .overflow (overflow),
      .sync_err (sync_err)
   );

   // {in_first on word 0, expected lane-0 marker, 80-bit group}
   localparam logic [81:0] VEC [6] = '{
      {1'b1, 1'b1, 80'h0123_4567_89AB_CDEF_F00D},
      {1'b0, 1'b0, 80'hFFFF_0000_AAAA_5555_1234},
      {1'b0, 1'b1, 80'h8000_0001_7FFF_FFFE_0F0F},
      {1'b1, 1'b1, 80'hDEAD_BEEF_CAFE_BABE_0000},
      {1'b0, 1'b0, 80'h1357_9BDF_2468_ACE0_FFFF},
      {1'b1, 1'b1, 80'hA5A5_5A5A_C3C3_3C3C_9999}
   };

   task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   task automatic send_word(input logic [19:0] d, input logic f);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
      in_first = f;
   endtask

   task automatic go_idle();
      @(negedge clk);
      in_valid = 1'b0;
      in_first = 1'b0;
      in_data  = '0;
   endtask

   task automatic send_group(input logic [79:0] g, input logic f);
      for (int j = 0; j < 4; j++)
         send_word(g[20*j +: 20], f && (j == 0));
      go_idle();
   endtask

   task automatic pop_all();
      rd_en = 5'h1F;
      @(negedge clk);
      rd_en = 5'h00;
   endtask

   function automatic logic [79:0] fill_group(input int i);
      logic [79:0] g;
      for (int k = 0; k < 5; k++)
         g[16*k +: 16] = 16'(16'h1000 * k + i);
      return g;
   endfunction

   task automatic apply_reset();
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_first = 1'b0;
      in_data  = '0;
      rd_en    = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      apply_reset();

      // R8: reset state
      check("R8 empty", 80'(empty), 80'h1F);
      check("R8 full", 80'(full), 80'h0);
      check("R8 overflow/sync_err", 80'({overflow, sync_err}), 80'h0);

      // R1 R2 R3: table of groups, each read back at once
      for (int v = 0; v < 6; v++) begin
         send_group(VEC[v][79:0], VEC[v][81]);
         check("R2 lanes written", 80'(empty), 80'h0);
         check("R1 group split", rd_data, VEC[v][79:0]);
         check("R3 set marker", 80'(rd_first), 80'({4'b0, VEC[v][80]}));
         pop_all();
         check("R4 drained", 80'(empty), 80'h1F);
      end
      check("R5 no false error", 80'(sync_err), 80'h0);

      // R7: invalid cycles with flag and data toggling are ignored mid-group
      send_word(20'h11111, 1'b1);
      send_word(20'h22222, 1'b0);
      @(negedge clk);
      in_valid = 1'b0;
      for (int c = 0; c < 4; c++) begin
         in_first = 1'b1;
         in_data  = 20'(20'hABCDE + c);
         @(negedge clk);
      end
      send_word(20'h33333, 1'b0);
      send_word(20'h44444, 1'b0);
      go_idle();
      check("R7 group intact", rd_data, 80'h44444_33333_22222_11111);
      check("R7 no error", 80'(sync_err), 80'h0);
      pop_all();

      // R5: flag at slot 2 drops the two partial words
      send_word(20'hBAD01, 1'b1);
      send_word(20'hBAD02, 1'b0);
      send_group(80'h76543_21FED_CBA98_76543, 1'b1);
      check("R5 sync_err set", 80'(sync_err), 80'h1);
      check("R5 realigned group", rd_data, 80'h76543_21FED_CBA98_76543);
      check("R5 marker on new set", 80'(rd_first), 80'h01);
      pop_all();
      check("R5 partial discarded", 80'(empty), 80'h1F);

      // R4: reads on empty lanes are ignored
      rd_en = 5'h1F;
      repeat (3) @(negedge clk);
      rd_en = 5'h00;
      send_group(80'hCAFE0_0000F_FFFF0_12345, 1'b1);
      check("R4 read on empty ignored", rd_data, 80'hCAFE0_0000F_FFFF0_12345);
      pop_all();
      check("R4 single entry", 80'(empty), 80'h1F);
      check("R5 error stays", 80'(sync_err), 80'h1);

      // R4 R6: fill to 16, overflow on the seventeenth group, drain in order
      for (int i = 0; i < 16; i++)
         send_group(fill_group(i), 1'b0);
      check("R4 full at 16", 80'(full), 80'h1F);
      check("R6 no overflow yet", 80'(overflow), 80'h0);
      send_group(fill_group(99), 1'b0);
      check("R6 overflow set", 80'(overflow), 80'h1F);
      for (int i = 0; i < 16; i++) begin
         check("R4 FIFO order", rd_data, fill_group(i));
         pop_all();
      end
      check("R6 dropped write", 80'(empty), 80'h1F);
      check("R6 overflow sticky", 80'(overflow), 80'h1F);

      // R8: reset clears sticky state
      apply_reset();
      check("R8 reset clears", 80'({overflow, sync_err}), 80'h0);
      check("R8 reset empty", 80'(empty), 80'h1F);

      finish_run();
   end

endmodule